// File: doc/BRIEF.md
# Flash read-mode data multiplexer

This block decides what a bus read of a parallel NOR flash returns. A separate command sequencer decodes the unlock and command writes and presents the latched command code and the write-cycle count. Depending on that code, a read returns one of four things: a word from the storage array, an identification word, the busy/status byte, or a byte of the device query table. The read result is registered and appears one clock after the read strobe.

The block holds the status byte itself. Program and erase start pulses load it. Every status read flips one of its bits, so software can poll for activity. An erase timer, counting clock cycles, flips the top status bit when the erase ends. It also gives the sequencer a one-cycle completion pulse, so the sequencer can return to read mode or to its bypass command-ready cycle.

The block also keeps a fast-path flag. When the flag is set, the surrounding system may serve reads straight from the array. A command write clears the flag. A run of idle reads, or an erase that finishes outside bypass mode, sets it again.

Top module: `flashrd_mux`

## Requirements
- R1: After reset, rdData is 0, fastPath is 1, eraseDone is 0 and the internal status byte is 0x00.
- R2: A read (rdEn high at a clock edge) updates rdData at that edge; with rdEn low rdData holds. With cmdCode 0x00 (idle), 0x80 (erase setup) or any code not listed in R3 to R9, a read returns arrayData.
- R3: With cmdCode 0x90 (autoselect), offsets (rdOffs) 0x00, 0x01 and 0x02 return MFR_ID, DEV_ID and 0 respectively.
- R4: With cmdCode 0x90, offset 0x0E returns EXT_ID0 and 0x0F returns EXT_ID1, except that an identifier equal to all ones returns arrayData instead; every other offset returns arrayData.
- R5: With cmdCode 0xA0 (program), 0x10 (chip erase) or 0x30 (sector erase), a read returns the status byte zero-extended, and each such read inverts status bit 6 after the read.
- R6: A progStart pulse loads the status byte with bit 7 = NOT progData7 and bits 6..0 = 1.
- R7: An eraseStart pulse clears the status byte. eraseDone is high for exactly one cycle, and bit 7 of the status is inverted at the clock edge that ends that cycle. That edge comes SECTOR_CYCLES edges after the start edge when eraseChip is 0, and SECTOR_CYCLES*CHIP_FACTOR edges after it when eraseChip is 1.
- R8: At erase completion with bypassOn 0, fastPath becomes 1; with bypassOn 1, completion leaves fastPath unchanged.
- R9: With cmdCode 0x98 (query), offsets below QUERY_LEN (0x52) return the table byte zero-extended. Offsets 0x00..0x0F read 0. Offsets 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59. Offset 0x13 reads 0x02, 0x27 reads log2 of the array size in bytes, 0x2C reads 0x01, and 0x2D reads the low byte of SECTOR_COUNT-1. Offsets of QUERY_LEN and above read 0.
- R10: A cmdWrite pulse clears fastPath and the idle-read count. While fastPath is 0, each read with cycleCnt 0 counts; reads with cycleCnt nonzero do not count. The read that takes the count past IDLE_READS (the 43rd by default) sets fastPath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe, one per read |
| rdOffs | input | 8 | Low byte of the word address of the read |
| arrayData | input | DATA_W | Array word at the read address |
| cmdCode | input | 8 | Command code latched by the sequencer |
| cycleCnt | input | 3 | Sequencer write-cycle count, 0 when idle |
| bypassOn | input | 1 | Sequencer bypass mode active |
| cmdWrite | input | 1 | Pulse on any command write |
| progStart | input | 1 | Pulse when a program is accepted |
| progData7 | input | 1 | Bit 7 of the programmed data |
| eraseStart | input | 1 | Pulse when an erase is accepted |
| eraseChip | input | 1 | With eraseStart: 1 chip erase, 0 sector erase |
| rdData | output | DATA_W | Registered read result |
| fastPath | output | 1 | Direct array reads allowed |
| eraseDone | output | 1 | One-cycle erase completion pulse |

## Verification
The bench goes after several boundary cases:
- Exactly 42 counted reads leave fastPath low, and the 43rd sets it. A counter off by one would release early or late.
- Reads taken while cycleCnt is nonzero must not advance the count.
- The all-ones extended identifier must fall through to array data. A design that returns it raw shows 0xFFFF.
- Status reads continue across the erase completion cycle, so the bit-6 toggle and the bit-7 flip land on the same edge. A design that lets one update override the other loses a flip there.
- The erase pulse is timed to the exact cycle for both erase lengths. Chip erase runs with bypass on, so a design that always re-enables the fast path after an erase fails.

// File: rtl/flashrd_pkg.sv
package flashrd_pkg;

  localparam logic [7:0] CMD_IDLE       = 8'h00;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL    = 8'h90;
  localparam logic [7:0] CMD_PROG       = 8'hA0;
  localparam logic [7:0] CMD_CHIP_ERASE = 8'h10;
  localparam logic [7:0] CMD_SECT_ERASE = 8'h30;
  localparam logic [7:0] CMD_QUERY      = 8'h98;

  typedef enum logic [2:0] {
    SEL_ARRAY,
    SEL_ZERO,
    SEL_MFR,
    SEL_DEV,
    SEL_EXT0,
    SEL_EXT1,
    SEL_STATUS,
    SEL_QUERY
  } rdSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   readHit;
    logic   toggleBusy;
    logic   eraseFlip;
    logic   loadProg;
    logic   loadErase;
    logic   progBit7;
    rdSel_t sel;
  } strobe_t;

  // device query table, uniform single erase region
  function automatic logic [7:0] queryByte(input logic [7:0] idx,
                                           input logic [7:0] sizeLog2,
                                           input logic [15:0] countM1,
                                           input logic [31:0] sectBytes);
    logic [7:0] q;
    case (idx)
      8'h10: q = 8'h51;
      8'h11: q = 8'h52;
      8'h12: q = 8'h59;
      8'h13: q = 8'h02;
      8'h15: q = 8'h31;
      8'h1B: q = 8'h27;
      8'h1C: q = 8'h36;
      8'h1F: q = 8'h07;
      8'h21: q = 8'h09;
      8'h22: q = 8'h0C;
      8'h23: q = 8'h01;
      8'h25: q = 8'h0A;
      8'h26: q = 8'h0D;
      8'h27: q = sizeLog2;
      8'h28: q = 8'h02;
      8'h2C: q = 8'h01;
      8'h2D: q = countM1[7:0];
      8'h2E: q = countM1[15:8];
      8'h2F: q = sectBytes[15:8];
      8'h30: q = sectBytes[23:16];
      8'h31: q = 8'h50;
      8'h32: q = 8'h52;
      8'h33: q = 8'h49;
      8'h34: q = 8'h31;
      8'h35: q = 8'h30;
      default: q = 8'h00;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/flashrd_ctrl.sv
module flashrd_ctrl
  import flashrd_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int SECTOR_CYCLES = 50,
  parameter int CHIP_FACTOR   = 10,
  parameter int IDLE_READS    = 42,
  parameter int QUERY_LEN     = 82,
  parameter logic [DATA_W-1:0] EXT_ID0 = '0,
  parameter logic [DATA_W-1:0] EXT_ID1 = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  logic [7:0] rdOffs,
  input  logic [7:0] cmdCode,
  input  logic [2:0] cycleCnt,
  input  logic       bypassOn,
  input  logic       cmdWrite,
  input  logic       progStart,
  input  logic       progData7,
  input  logic       eraseStart,
  input  logic       eraseChip,
  output strobe_t    stb,
  output logic       fastPath,
  output logic       eraseDone
);

  localparam int CHIP_CYCLES = SECTOR_CYCLES * CHIP_FACTOR;
  localparam int CNT_W       = $clog2(CHIP_CYCLES + 1);
  localparam int RC_W        = $clog2(IDLE_READS + 2);
  localparam logic EXT0_NONE = (EXT_ID0 == '1);
  localparam logic EXT1_NONE = (EXT_ID1 == '1);

  logic [CNT_W-1:0] eraseCnt;
  logic             eraseBusy;
  logic [RC_W-1:0]  readCnt;
  logic             statusCmd;
  rdSel_t           sel;

  // read source selection
  always_comb begin
    sel       = SEL_ARRAY;
    statusCmd = 1'b0;
    case (cmdCode)
      CMD_AUTOSEL: begin
        case (rdOffs)
          8'h00:   sel = SEL_MFR;
          8'h01:   sel = SEL_DEV;
          8'h02:   sel = SEL_ZERO;
          8'h0E:   sel = EXT0_NONE ? SEL_ARRAY : SEL_EXT0;
          8'h0F:   sel = EXT1_NONE ? SEL_ARRAY : SEL_EXT1;
          default: sel = SEL_ARRAY;
        endcase
      end
      CMD_PROG, CMD_CHIP_ERASE, CMD_SECT_ERASE: begin
        sel       = SEL_STATUS;
        statusCmd = 1'b1;
      end
      CMD_QUERY: sel = (32'(rdOffs) < QUERY_LEN) ? SEL_QUERY : SEL_ZERO;
      default:   sel = SEL_ARRAY;
    endcase
  end

  assign eraseDone = eraseBusy && (eraseCnt == CNT_W'(1));

  always_comb begin
    stb.readHit    = rdEn;
    stb.toggleBusy = rdEn && statusCmd;
    stb.eraseFlip  = eraseDone;
    stb.loadProg   = progStart;
    stb.loadErase  = eraseStart;
    stb.progBit7   = progData7;
    stb.sel        = sel;
  end

  // erase delay timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBusy <= 1'b0;
      eraseCnt  <= '0;
    end else if (eraseStart) begin
      eraseBusy <= 1'b1;
      eraseCnt  <= eraseChip ? CNT_W'(CHIP_CYCLES) : CNT_W'(SECTOR_CYCLES);
    end else if (eraseDone) begin
      eraseBusy <= 1'b0;
    end else if (eraseBusy) begin
      eraseCnt <= eraseCnt - CNT_W'(1);
    end
  end

  // fast-path tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastPath <= 1'b1;
      readCnt  <= '0;
    end else if (cmdWrite) begin
      fastPath <= 1'b0;
      readCnt  <= '0;
    end else if (eraseDone && !bypassOn) begin
      fastPath <= 1'b1;
      readCnt  <= '0;
    end else if (rdEn && !fastPath && (cycleCnt == 3'd0)) begin
      if (readCnt == RC_W'(IDLE_READS)) begin
        fastPath <= 1'b1;
        readCnt  <= '0;
      end else begin
        readCnt <= readCnt + RC_W'(1);
      end
    end
  end

endmodule

// File: rtl/flashrd_dp.sv
module flashrd_dp
  import flashrd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_ID  = '0,
  parameter logic [DATA_W-1:0] DEV_ID  = '0,
  parameter logic [DATA_W-1:0] EXT_ID0 = '0,
  parameter logic [DATA_W-1:0] EXT_ID1 = '1,
  parameter logic [7:0]  SIZE_LOG2  = 8'd0,
  parameter logic [15:0] COUNT_M1   = 16'd0,
  parameter logic [31:0] SECT_BYTES = 32'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        rdOffs,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - 8;

  logic [7:0]        statusQ;
  logic [7:0]        statusD;
  logic [DATA_W-1:0] readVal;

  always_comb begin
    statusD = statusQ;
    if (stb.loadProg) begin
      statusD = {~stb.progBit7, 7'h7F};
    end else if (stb.loadErase) begin
      statusD = 8'h00;
    end else begin
      if (stb.eraseFlip)  statusD[7] = ~statusQ[7];
      if (stb.toggleBusy) statusD[6] = ~statusQ[6];
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_ZERO:   readVal = '0;
      SEL_MFR:    readVal = MFR_ID;
      SEL_DEV:    readVal = DEV_ID;
      SEL_EXT0:   readVal = EXT_ID0;
      SEL_EXT1:   readVal = EXT_ID1;
      SEL_STATUS: readVal = {{PAD_W{1'b0}}, statusQ};
      SEL_QUERY:  readVal = {{PAD_W{1'b0}},
                             queryByte(rdOffs, SIZE_LOG2, COUNT_M1, SECT_BYTES)};
      default:    readVal = arrayData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= 8'h00;
      rdData  <= '0;
    end else begin
      statusQ <= statusD;
      if (stb.readHit) rdData <= readVal;
    end
  end

endmodule

// File: rtl/flashrd_mux.sv
module flashrd_mux
  import flashrd_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int SECTOR_BYTES  = 65536,
  parameter int SECTOR_COUNT  = 64,
  parameter int SECTOR_CYCLES = 50,
  parameter int CHIP_FACTOR   = 10,
  parameter int IDLE_READS    = 42,
  parameter int QUERY_LEN     = 82,
  parameter logic [DATA_W-1:0] MFR_ID  = 16'h0001,
  parameter logic [DATA_W-1:0] DEV_ID  = 16'h227E,
  parameter logic [DATA_W-1:0] EXT_ID0 = 16'h2210,
  parameter logic [DATA_W-1:0] EXT_ID1 = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [7:0]        rdOffs,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [7:0]        cmdCode,
  input  logic [2:0]        cycleCnt,
  input  logic              bypassOn,
  input  logic              cmdWrite,
  input  logic              progStart,
  input  logic              progData7,
  input  logic              eraseStart,
  input  logic              eraseChip,
  output logic [DATA_W-1:0] rdData,
  output logic              fastPath,
  output logic              eraseDone
);

  localparam longint CHIP_BYTES = longint'(SECTOR_BYTES) * SECTOR_COUNT;
  localparam logic [7:0]  SIZE_LOG2  = 8'($clog2(CHIP_BYTES));
  localparam logic [15:0] COUNT_M1   = 16'(SECTOR_COUNT - 1);
  localparam logic [31:0] SECT_BYTES = 32'(SECTOR_BYTES);

  strobe_t stb;

  flashrd_ctrl #(
    .DATA_W(DATA_W), .SECTOR_CYCLES(SECTOR_CYCLES), .CHIP_FACTOR(CHIP_FACTOR),
    .IDLE_READS(IDLE_READS), .QUERY_LEN(QUERY_LEN),
    .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdOffs(rdOffs), .cmdCode(cmdCode),
    .cycleCnt(cycleCnt), .bypassOn(bypassOn), .cmdWrite(cmdWrite),
    .progStart(progStart), .progData7(progData7), .eraseStart(eraseStart),
    .eraseChip(eraseChip), .stb(stb), .fastPath(fastPath), .eraseDone(eraseDone)
  );

  flashrd_dp #(
    .DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1), .SIZE_LOG2(SIZE_LOG2),
    .COUNT_M1(COUNT_M1), .SECT_BYTES(SECT_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdOffs(rdOffs),
    .arrayData(arrayData), .rdData(rdData)
  );

endmodule

// File: rtl/flashrd_mux_chk.sv
module flashrd_mux_chk #(
  parameter int DATA_W    = 16,
  parameter int QUERY_LEN = 82
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [7:0]        rdOffs,
  input logic [7:0]        cmdCode,
  input logic              bypassOn,
  input logic              cmdWrite,
  input logic              progStart,
  input logic              eraseStart,
  input logic [DATA_W-1:0] rdData,
  input logic              fastPath,
  input logic              eraseDone
);

  logic statRd;
  logic quietRd;
  assign statRd  = rdEn && (cmdCode == 8'hA0 || cmdCode == 8'h10 || cmdCode == 8'h30);
  assign quietRd = statRd && !progStart && !eraseStart;

  // R5: back-to-back status reads differ in bit 6
  a_r5_status_toggle: assert property (@(posedge clk) disable iff (!rstN)
    quietRd ##1 statRd |=> rdData[6] != $past(rdData[6]));

  // R3: protection word reads zero
  a_r3_protect_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cmdCode == 8'h90 && rdOffs == 8'h02) |=> rdData == '0);

  // R9: query offsets past the table read zero
  a_r9_query_beyond: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cmdCode == 8'h98 && 32'(rdOffs) >= QUERY_LEN) |=> rdData == '0);

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (eraseDone && !eraseStart) |=> !eraseDone);

  // R10: command write drops the fast path
  a_r10_cmd_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> !fastPath);

  // R8: completion outside bypass restores the fast path
  a_r8_done_fast: assert property (@(posedge clk) disable iff (!rstN)
    (eraseDone && !bypassOn && !cmdWrite) |=> fastPath);

  // R8: completion in bypass leaves a cleared fast path cleared
  a_r8_bypass_keep: assert property (@(posedge clk) disable iff (!rstN)
    (eraseDone && bypassOn && !cmdWrite && !rdEn && !fastPath) |=> !fastPath);

endmodule

bind flashrd_mux flashrd_mux_chk #(.DATA_W(DATA_W), .QUERY_LEN(QUERY_LEN)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdOffs(rdOffs), .cmdCode(cmdCode),
  .bypassOn(bypassOn), .cmdWrite(cmdWrite), .progStart(progStart),
  .eraseStart(eraseStart), .rdData(rdData), .fastPath(fastPath),
  .eraseDone(eraseDone)
);

// File: tb/flashrd_mux_test.sv
`timescale 1ns/1ps
module flashrd_mux_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdOffs = 8'h00;
  logic [15:0] arrayData = 16'h0000;
  logic [7:0]  cmdCode = 8'h00;
  logic [2:0]  cycleCnt = 3'd0;
  logic        bypassOn = 1'b0;
  logic        cmdWrite = 1'b0;
  logic        progStart = 1'b0;
  logic        progData7 = 1'b0;
  logic        eraseStart = 1'b0;
  logic        eraseChip = 1'b0;
  logic [15:0] rdData;
  logic        fastPath;
  logic        eraseDone;

  always #2 clk = ~clk;

  flashrd_mux uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdOffs(rdOffs), .arrayData(arrayData),
    .cmdCode(cmdCode), .cycleCnt(cycleCnt), .bypassOn(bypassOn),
    .cmdWrite(cmdWrite), .progStart(progStart), .progData7(progData7),
    .eraseStart(eraseStart), .eraseChip(eraseChip), .rdData(rdData),
    .fastPath(fastPath), .eraseDone(eraseDone)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    comparing = 1'b0;
  bit    finished  = 1'b0;

  // ---------------- behavioural reference ----------------
  logic [15:0] mRd;
  logic [7:0]  mStatus;
  bit          mFast;
  bit          mBusy;
  int          mCnt;
  int          mReadCnt;

  function automatic logic [15:0] pat(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  function automatic logic [7:0] qExp(input logic [7:0] i);
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h02;
      8'h27: return 8'd22;
      8'h2C: return 8'h01;
      8'h2D: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] expRead();
    logic [15:0] v;
    v = arrayData;
    if (cmdCode == 8'h90) begin
      if (rdOffs == 8'h00) v = 16'h0001;
      else if (rdOffs == 8'h01) v = 16'h227E;
      else if (rdOffs == 8'h02) v = 16'h0000;
      else if (rdOffs == 8'h0E) v = 16'h2210;
    end else if (cmdCode == 8'hA0 || cmdCode == 8'h10 || cmdCode == 8'h30) begin
      v = {8'h00, mStatus};
    end else if (cmdCode == 8'h98) begin
      v = (rdOffs < 8'h52) ? {8'h00, qExp(rdOffs)} : 16'h0000;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    bit done;
    bit stat;
    if (!rstN) begin
      mRd = 16'h0; mStatus = 8'h00; mFast = 1; mBusy = 0; mCnt = 0; mReadCnt = 0;
    end else begin
      done = mBusy && (mCnt == 1);
      stat = rdEn && (cmdCode == 8'hA0 || cmdCode == 8'h10 || cmdCode == 8'h30);
      if (rdEn) mRd = expRead();
      if (progStart) mStatus = {~progData7, 7'h7F};
      else if (eraseStart) mStatus = 8'h00;
      else begin
        if (done) mStatus = mStatus ^ 8'h80;
        if (stat) mStatus = mStatus ^ 8'h40;
      end
      if (eraseStart) begin mBusy = 1; mCnt = eraseChip ? 500 : 50; end
      else if (done) mBusy = 0;
      else if (mBusy) mCnt = mCnt - 1;
      if (cmdWrite) begin mFast = 0; mReadCnt = 0; end
      else if (done && !bypassOn) begin mFast = 1; mReadCnt = 0; end
      else if (rdEn && !mFast && cycleCnt == 3'd0) begin
        mReadCnt = mReadCnt + 1;
        if (mReadCnt > 42) begin mFast = 1; mReadCnt = 0; end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rstN) begin
      check(curReq, "rdData", int'(rdData), int'(mRd));
      check(curReq, "fastPath", int'(fastPath), int'(mFast));
      check(curReq, "eraseDone", int'(eraseDone), int'(mBusy && mCnt == 1));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic rd(input logic [7:0] cmd, input logic [7:0] offs, input logic [2:0] cyc);
    rdEn = 1; rdOffs = offs; arrayData = pat(offs); cmdCode = cmd; cycleCnt = cyc;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      arrayData = arrayData + 16'h0111;
      @(negedge clk);
    end
  endtask

  task automatic cmdPulse();
    cmdWrite = 1; @(negedge clk); cmdWrite = 0;
  endtask

  task automatic prog(input logic d7);
    progStart = 1; progData7 = d7; @(negedge clk); progStart = 0;
  endtask

  task automatic erase(input logic chip);
    eraseStart = 1; eraseChip = chip; @(negedge clk); eraseStart = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int waitN;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    check("R1", "reset rdData", int'(rdData), 0);
    check("R1", "reset fastPath", int'(fastPath), 1);
    check("R1", "reset eraseDone", int'(eraseDone), 0);
    comparing = 1;

    // R2: array reads and hold
    curReq = "R2";
    rd(8'h00, 8'h12, 3'd0);
    check("R2", "array read", int'(rdData), int'(pat(8'h12)));
    rd(8'h80, 8'hC4, 3'd0);
    rd(8'h55, 8'h07, 3'd0);
    idle(4);
    check("R2", "hold after idle", int'(rdData), int'(pat(8'h07)));

    // R10: fast-path release after idle reads
    curReq = "R10";
    cmdPulse();
    check("R10", "cleared", int'(fastPath), 0);
    for (int i = 0; i < 5; i++) rd(8'h00, 8'(i), 3'd3);
    for (int i = 0; i < 42; i++) rd(8'h00, 8'(i + 8), 3'd0);
    check("R10", "after 42 reads", int'(fastPath), 0);
    rd(8'h00, 8'h99, 3'd0);
    check("R10", "after 43 reads", int'(fastPath), 1);
    cmdPulse();
    for (int i = 0; i < 20; i++) rd(8'h00, 8'(i), 3'd0);
    cmdPulse();
    for (int i = 0; i < 42; i++) rd(8'h00, 8'(i), 3'd0);
    check("R10", "count restarted", int'(fastPath), 0);

    // R3 / R4: autoselect
    curReq = "R3";
    rd(8'h90, 8'h00, 3'd3);
    check("R3", "mfr id", int'(rdData), 16'h0001);
    rd(8'h90, 8'h01, 3'd3);
    check("R3", "dev id", int'(rdData), 16'h227E);
    rd(8'h90, 8'h02, 3'd3);
    check("R3", "protection", int'(rdData), 0);
    curReq = "R4";
    rd(8'h90, 8'h0E, 3'd3);
    check("R4", "ext id 0", int'(rdData), 16'h2210);
    rd(8'h90, 8'h0F, 3'd3);
    check("R4", "ext id 1 all ones", int'(rdData), int'(pat(8'h0F)));
    rd(8'h90, 8'h03, 3'd3);
    rd(8'h90, 8'h40, 3'd3);

    // R9: query table
    curReq = "R9";
    begin
      logic [7:0] qList [12] = '{8'h00, 8'h05, 8'h10, 8'h11, 8'h12, 8'h13,
                                 8'h27, 8'h2C, 8'h2D, 8'h52, 8'h60, 8'hFF};
      for (int i = 0; i < 12; i++) rd(8'h98, qList[i], 3'd0);
    end
    rd(8'h98, 8'h10, 3'd0);
    check("R9", "query Q", int'(rdData), 16'h0051);
    rd(8'h98, 8'h52, 3'd0);
    check("R9", "query beyond", int'(rdData), 0);

    // R6 / R5: program status
    curReq = "R6";
    prog(1'b1);
    rd(8'hA0, 8'h00, 3'd4);
    check("R6", "prog status d7=1", int'(rdData), 16'h007F);
    curReq = "R5";
    rd(8'hA0, 8'h00, 3'd4);
    check("R5", "toggle bit 6", int'(rdData), 16'h003F);
    rd(8'hA0, 8'h00, 3'd4);
    check("R5", "toggle back", int'(rdData), 16'h007F);
    curReq = "R6";
    prog(1'b0);
    rd(8'hA0, 8'h00, 3'd4);
    check("R6", "prog status d7=0", int'(rdData), 16'h00FF);

    // R7 / R8: sector erase outside bypass, polled continuously
    curReq = "R7";
    bypassOn = 0;
    cmdPulse();
    erase(1'b0);
    waitN = 0;
    for (int i = 1; i <= 60; i++) begin
      rd(8'h30, 8'h00, 3'd6);
      if (eraseDone && waitN == 0) waitN = i;
    end
    check("R7", "sector erase length", waitN, 49);
    curReq = "R8";
    check("R8", "fast after erase", int'(fastPath), 1);

    // R7 / R8: chip erase in bypass
    curReq = "R7";
    bypassOn = 1;
    cmdPulse();
    erase(1'b1);
    rd(8'h10, 8'h00, 3'd6);
    check("R7", "erase clears status", int'(rdData), 16'h0000);
    waitN = 0;
    for (int i = 2; i <= 510; i++) begin
      idle(1);
      if (eraseDone && waitN == 0) waitN = i;
    end
    check("R7", "chip erase length", waitN, 499);
    rd(8'h10, 8'h00, 3'd6);
    check("R7", "bit 7 flipped", int'(rdData), 16'h00C0);
    curReq = "R8";
    check("R8", "bypass keeps fast low", int'(fastPath), 0);
    bypassOn = 0;
    idle(3);

    comparing = 0;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule